// File: doc/BRIEF.md
# Fractional Oversample Tick Generator

This block turns a system clock into the 16x oversampling tick that a serial transmitter and receiver share. The clock first passes through a small reference pre-divider, picked by a 3-bit code, that divides by 1 to 7. Each divided-reference enable then feeds an accumulator. The accumulator applies a fractional ratio built from two 16-bit registers: a step value and a wrap value. The tick rate is the divided reference scaled by (step+1)/(wrap+1). One serial bit lasts sixteen ticks, so the bit rate is the divided reference over 16·(wrap+1)/(step+1).

Software writes the step register first. That write only stages the value. Writing the wrap register is the single event that loads both values into the running generator and restarts the accumulator. Until the first such load after reset, the generator emits no ticks. The divided-reference enable runs from reset onward and is brought out as well.

Top module: `baud_tick_gen`

## Requirements
- R1: `refEnable` pulses for one cycle once every N cycles. N comes from `divCode`: 3'b101→1, 3'b100→2, 3'b011→3, 3'b010→4, 3'b001→5, 3'b000→6, 3'b110→7. The unused code 3'b111 also gives 1.
- R2: Each tick lasts one cycle and rises on the cycle after a `refEnable` pulse. Over any run of (wrap+1) consecutive enables, the generator gives exactly (step+1) ticks whenever step < wrap.
- R3: Step and wrap are both 16 bits wide. The full range works without overflow, for example step=65535 with wrap=65534, and step=0 with wrap=1000.
- R4: A write with `wrSel`=0 only stages a new step value. If no wrap write follows, the active tick rate does not change.
- R5: A write with `wrSel`=1 loads wrap from `wrData` and loads step from the staged value. If the wrap write comes before a new step write, the rate uses the step value that was staged before it.
- R6: If step ≥ wrap, the generator ticks after every enable, never more than once per enable, and carries the remainder forward.
- R7: A wrap write clears the accumulator and suppresses the tick in the cycle it commits. Any fraction built up before the write is discarded.
- R8: Reset clears the pre-divider count and the accumulator, loads step = wrap = 0, and holds `oversampleTick` low until the first wrap write.
- R9: With step=15, one tick comes every (wrap+1)/16 enables, so the bit rate is the divided reference over (wrap+1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrSel | input | 1 | Register select: 0 = step, 1 = wrap (commit) |
| wrStb | input | 1 | Single-cycle write strobe |
| wrData | input | 16 | Write data |
| divCode | input | 3 | Reference pre-divider code |
| oversampleTick | output | 1 | Single-cycle 16x oversample tick |
| refEnable | output | 1 | Divided-reference enable |

## Verification
The checks on enable spacing assume `divCode` stays stable while a divided period runs. Each one applies only over cycles where the code did not change. The bench changes the code only between measurements and lets the new period settle before it counts anything. The no-tick checks assume that a wrap write is a single-cycle strobe. The bench gives every write exactly one cycle. It measures each window from the cycle after a commit, over a whole number of divided periods, so the expected tick and enable counts are exact whatever the pre-divider phase.

// File: rtl/baud_pkg.sv
package baud_pkg;

  localparam int CODE_W = 3;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic refEn;   // divided-reference enable this cycle
    logic commit;  // wrap register written: load both values
  } baudStrobes_t;

  // Non-monotonic pre-divider code to divide ratio
  function automatic logic [CODE_W-1:0] divFromCode(input logic [CODE_W-1:0] code);
    case (code)
      3'b101:  divFromCode = 3'd1;
      3'b100:  divFromCode = 3'd2;
      3'b011:  divFromCode = 3'd3;
      3'b010:  divFromCode = 3'd4;
      3'b001:  divFromCode = 3'd5;
      3'b000:  divFromCode = 3'd6;
      3'b110:  divFromCode = 3'd7;
      default: divFromCode = 3'd1;  // spare code behaves as divide-by-1
    endcase
  endfunction

endpackage

// File: rtl/baud_ctrl.sv
module baud_ctrl
  import baud_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrSel,
  input  logic                 wrStb,
  input  logic [REG_W-1:0]     wrData,
  input  logic [CODE_W-1:0]    divCode,
  output baudStrobes_t         strobes,
  output logic [REG_W-1:0]     incStaged
);

  localparam int CNT_W = CODE_W;

  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] divLast;
  logic             refEnC;

  assign divLast = divFromCode(divCode) - CNT_W'(1);
  // >= so a code change to a shorter period never overshoots
  assign refEnC  = (preCnt >= divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (refEnC) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + CNT_W'(1);
    end
  end

  // Step value is only staged here; the datapath picks it up on commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incStaged <= '0;
    end else if (wrStb && !wrSel) begin
      incStaged <= wrData;
    end
  end

  always_comb begin
    strobes.refEn  = refEnC;
    strobes.commit = wrStb && wrSel;
  end

endmodule

// File: rtl/baud_datapath.sv
module baud_datapath
  import baud_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  baudStrobes_t      strobes,
  input  logic [REG_W-1:0]  incStaged,
  input  logic [REG_W-1:0]  modData,
  output logic              tick
);

  // Two guard bits: step+1 and wrap+1 reach 2^REG_W, their sum 2^(REG_W+1)
  localparam int ACC_W = REG_W + 2;

  logic [REG_W-1:0] incAct;
  logic [REG_W-1:0] modAct;
  logic [ACC_W-1:0] acc;
  logic             armed;
  logic             tickQ;

  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] limit;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] rem;
  logic [ACC_W-1:0] nextAcc;
  logic             wrap;

  always_comb begin
    step    = ACC_W'(incAct) + ACC_W'(1);
    limit   = ACC_W'(modAct) + ACC_W'(1);
    sum     = acc + step;
    wrap    = (sum >= limit);
    rem     = sum - limit;
    // Carry the remainder but keep it below limit, so acc stays bounded
    if (!wrap) begin
      nextAcc = sum;
    end else if (rem >= limit) begin
      nextAcc = ACC_W'(modAct);
    end else begin
      nextAcc = rem;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      incAct <= '0;
      modAct <= '0;
      acc    <= '0;
      armed  <= 1'b0;
      tickQ  <= 1'b0;
    end else if (strobes.commit) begin
      incAct <= incStaged;
      modAct <= modData;
      acc    <= '0;
      armed  <= 1'b1;
      tickQ  <= 1'b0;
    end else if (armed && strobes.refEn) begin
      acc    <= nextAcc;
      tickQ  <= wrap;
    end else begin
      tickQ  <= 1'b0;
    end
  end

  assign tick = tickQ;

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrSel,
  input  logic              wrStb,
  input  logic [REG_W-1:0]  wrData,
  input  logic [2:0]        divCode,
  output logic              oversampleTick,
  output logic              refEnable
);

  baudStrobes_t     strobes;
  logic [REG_W-1:0] incStaged;

  baud_ctrl #(.REG_W(REG_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrSel     (wrSel),
    .wrStb     (wrStb),
    .wrData    (wrData),
    .divCode   (divCode),
    .strobes   (strobes),
    .incStaged (incStaged)
  );

  baud_datapath #(.REG_W(REG_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .incStaged (incStaged),
    .modData   (wrData),
    .tick      (oversampleTick)
  );

  assign refEnable = strobes.refEn;

endmodule

// File: rtl/baud_chk.sv
module baud_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrSel,
  input logic       wrStb,
  input logic [2:0] divCode,
  input logic       refEnable,
  input logic       oversampleTick
);

  logic seenCommit;
  logic fastCode;

  assign fastCode = (divCode == 3'b101) || (divCode == 3'b111);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenCommit <= 1'b0;
    end else if (wrStb && wrSel) begin
      seenCommit <= 1'b1;
    end
  end

  AST_FAST_CODE_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    fastCode |-> refEnable); // R1

  AST_REF_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(refEnable) && $stable(divCode) && !fastCode) |-> !refEnable); // R1

  AST_TICK_AFTER_REF: assert property (@(posedge clk) disable iff (!rstN)
    oversampleTick |-> $past(refEnable)); // R2

  AST_COMMIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && wrSel) |=> !oversampleTick); // R7

  AST_NO_TICK_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    !seenCommit |-> !oversampleTick); // R8

endmodule

bind baud_tick_gen baud_chk uChk (
  .clk            (clk),
  .rstN           (rstN),
  .wrSel          (wrSel),
  .wrStb          (wrStb),
  .divCode        (divCode),
  .refEnable      (refEnable),
  .oversampleTick (oversampleTick)
);

// File: tb/sim_baud_tick_gen.sv
`timescale 1ns/1ps
module sim_baud_tick_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrSel = 1'b0;
  logic        wrStb = 1'b0;
  logic [15:0] wrData = '0;
  logic [2:0]  divCode = 3'b101;
  logic        oversampleTick;
  logic        refEnable;

  always #4 clk = ~clk;  // 125 MHz

  baud_tick_gen u0 (
    .clk            (clk),
    .rstN           (rstN),
    .wrSel          (wrSel),
    .wrStb          (wrStb),
    .wrData         (wrData),
    .divCode        (divCode),
    .oversampleTick (oversampleTick),
    .refEnable      (refEnable)
  );

  typedef struct {
    int    n;
    int    expRef;
    int    expTick;
    string tag;
  } item_t;

  item_t q[$];
  int compared   = 0;
  int mismatched = 0;
  int pushed     = 0;
  int done       = 0;
  bit finished   = 1'b0;

  task automatic check(input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Monitor: counts enables over [0,n) and ticks over [1,n] from the push cycle
  initial begin
    forever begin
      item_t it;
      int refs;
      int ticks;
      wait (q.size() > 0);
      it = q.pop_front();
      refs = 0;
      ticks = 0;
      for (int i = 0; i <= it.n; i++) begin
        if (i > 0) @(negedge clk);
        if (i < it.n && refEnable) refs++;
        if (i > 0 && oversampleTick) ticks++;
      end
      check(refs, it.expRef, {it.tag, " enables"});
      check(ticks, it.expTick, {it.tag, " ticks"});
      done++;
    end
  end

  task automatic pushItem(input int n, input int er, input int et, input string tag);
    item_t it;
    it.n = n; it.expRef = er; it.expTick = et; it.tag = tag;
    q.push_back(it);
    pushed++;
    wait (done == pushed);
  endtask

  // Called at a negedge; returns at the following negedge
  task automatic writeReg(input logic sel, input logic [15:0] d);
    wrSel  = sel;
    wrData = d;
    wrStb  = 1'b1;
    @(negedge clk);
    wrStb  = 1'b0;
  endtask

  task automatic commitAndMeasure(input logic [15:0] wrapV, input int n,
                                  input int er, input int et, input string tag);
    writeReg(1'b1, wrapV);
    pushItem(n, er, et, tag);
  endtask

  task automatic setCode(input logic [2:0] c);
    divCode = c;
    repeat (10) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(int'(oversampleTick), 0, "R8 tick low in reset");
    rstN = 1'b1;
    // R8: enables run, no tick before first commit
    pushItem(60, 60, 0, "R8 before commit");

    // R9: step 15, wrap 63 -> one tick per 4 enables
    writeReg(1'b0, 16'd15);
    commitAndMeasure(16'd63, 64, 64, 16, "R9 step15 wrap63");

    // R2: fractional 3/5 at divide-by-2
    setCode(3'b100);
    writeReg(1'b0, 16'd2);
    commitAndMeasure(16'd4, 40, 20, 12, "R2 ratio 3/5 div2");

    // R4: staged step alone leaves the rate unchanged
    writeReg(1'b0, 16'd0);
    pushItem(40, 20, 12, "R4 staged step only");

    // R5: wrap written with step 0 staged, divide-by-6
    setCode(3'b000);
    commitAndMeasure(16'd7, 96, 16, 2, "R5 ratio 1/8 div6");
    writeReg(1'b0, 16'd7);
    pushItem(96, 16, 2, "R5 new step not yet active");
    commitAndMeasure(16'd7, 48, 8, 8, "R6 step equals wrap");

    // R6: step above wrap, divide-by-4
    setCode(3'b010);
    writeReg(1'b0, 16'd9);
    commitAndMeasure(16'd3, 40, 10, 10, "R6 step above wrap div4");

    // R1: remaining codes with one tick per enable
    writeReg(1'b0, 16'd15);
    setCode(3'b110);
    commitAndMeasure(16'd15, 42, 6, 6, "R1 code110 div7");
    setCode(3'b111);
    commitAndMeasure(16'd15, 20, 20, 20, "R1 code111 div1");
    setCode(3'b011);
    commitAndMeasure(16'd15, 30, 10, 10, "R1 code011 div3");
    setCode(3'b001);
    commitAndMeasure(16'd15, 25, 5, 5, "R1 code001 div5");

    // R3: full-width values
    setCode(3'b101);
    writeReg(1'b0, 16'hFFFF);
    commitAndMeasure(16'hFFFE, 30, 30, 30, "R3 step max");
    writeReg(1'b0, 16'd0);
    commitAndMeasure(16'd1000, 2002, 2002, 2, "R3 wrap 1000");

    // R7: recommit clears the accumulated fraction
    writeReg(1'b0, 16'd0);
    commitAndMeasure(16'd3, 2, 2, 0, "R7 first partial");
    commitAndMeasure(16'd3, 3, 3, 0, "R7 after recommit");

    // R8: mid-run reset drops back to no ticks
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check(int'(oversampleTick), 0, "R8 tick low in second reset");
    rstN = 1'b1;
    pushItem(30, 30, 0, "R8 after second reset");

    summary();
  end

endmodule